// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit carries out the single-bit instructions of a small processor on an 8-bit operand. It receives the operand byte, a bit number, a 4-bit operation code, and the current carry (C) and zero (Z) flags. Some operations modify one bit of the byte and ask for the byte to be written back. The others only read the selected bit and update the flags.

The fourteen operations share one datapath. A mask selects one bit of the byte. Four operations change the byte: set, clear, invert and store-carry. Store-carry also has an inverted form. The read-only group has three kinds. Test writes Z. Load writes C. AND, OR and XOR merge the bit into C, and each of these has a form that uses the complement of the bit. Fetching the byte from a register or memory and writing it back is left to the surrounding core. The unit registers its result and presents it one clock after the request.

Top module: `bitman_unit`

## Requirements
- R1: A request sampled with `req_valid` high on a rising edge produces `rsp_valid` high for exactly the following cycle. At that time `rsp_byte`, `rsp_we`, `rsp_c` and `rsp_z` carry the result of that request. In a cycle with no request, `rsp_valid` and `rsp_we` are low and the data outputs keep their last values.
- R2: Only the low three bits of `req_bitnum` select the bit. The mask is 1 shifted left by that value. Higher bits of `req_bitnum` have no effect.
- R3: Op 0 (set) returns the byte ORed with the mask. Op 1 (clear) returns the byte ANDed with the inverted mask. Op 2 (invert) returns the byte XORed with the mask.
- R4: Op 3 (test) sets Z to 1 when the selected bit is 0 and clears Z otherwise. The byte is returned unchanged and there is no write-back.
- R5: Op 4 (load) copies the selected bit into C. Op 5 (inverted load) copies its complement into C.
- R6: Op 6 (store) returns the byte with the selected bit replaced by C. Op 7 (inverted store) replaces the bit with the complement of C.
- R7: The following ops set C to the bit (or its complement) combined with C, and do not write back:

  | Op | Operation |
  |----|-----------|
  | 8 | bit AND C |
  | 9 | NOT bit AND C |
  | 10 | bit OR C |
  | 11 | NOT bit OR C |
  | 12 | bit XOR C |
  | 13 | NOT bit XOR C |

- R8: `rsp_we` is high only for ops 0, 1, 2, 6 and 7. Codes 14 and 15 return the byte and both flags unchanged, with no write-back.
- R9: A flag that an operation does not name passes through from `c_in`/`z_in` unchanged. Only op 3 changes Z. Only ops 4, 5 and 8 to 13 change C.
- R10: While reset is asserted and after it is released, all outputs are 0 until the first request completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | Operation code (0 to 13, 14/15 no-op) |
| req_bitnum | input | NUM_W (8) | Bit number; low three bits used |
| req_byte | input | DATA_W (8) | Operand byte |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_byte | output | DATA_W (8) | Resulting byte |
| rsp_we | output | 1 | Write-back enable for `rsp_byte` |
| rsp_c | output | 1 | New carry flag |
| rsp_z | output | 1 | New zero flag |

## Verification
Every operation is driven across all eight bit positions, both carry values and both zero values. This catches a design that swaps the inverted and plain forms, or that applies the inversion to C instead of to the bit.

Bit numbers above 7 are sent to expose a mask built from the full bit-number field. Such a design would clear or set nothing.

The read-only operations are checked for a stray `rsp_we` and for a corrupted byte. The flag each operation does not name is checked for pass-through, so a unit that clobbers Z on a load, or C on a test, is reported.

The two unused codes and idle cycles are also checked. This catches a unit that writes back on garbage codes or keeps `rsp_we` asserted after a request.

// File: rtl/bitman_pkg.sv
package bitman_pkg;
  typedef enum logic [3:0] {
    BM_SET  = 4'd0,
    BM_CLR  = 4'd1,
    BM_INV  = 4'd2,
    BM_TST  = 4'd3,
    BM_LD   = 4'd4,
    BM_ILD  = 4'd5,
    BM_ST   = 4'd6,
    BM_IST  = 4'd7,
    BM_AND  = 4'd8,
    BM_IAND = 4'd9,
    BM_OR   = 4'd10,
    BM_IOR  = 4'd11,
    BM_XOR  = 4'd12,
    BM_IXOR = 4'd13,
    BM_RSV0 = 4'd14,
    BM_RSV1 = 4'd15
  } bm_op_e;

  function automatic logic bm_writes(input bm_op_e op);
    return (op == BM_SET) || (op == BM_CLR) || (op == BM_INV) ||
           (op == BM_ST)  || (op == BM_IST);
  endfunction
endpackage

// File: rtl/bitman_decode.sv
module bitman_decode #(
  parameter int DATA_W = 8,
  parameter int NUM_W  = 8
) (
  input  logic [NUM_W-1:0]  bitnum,
  input  logic [DATA_W-1:0] byte_in,
  output logic [DATA_W-1:0] mask,
  output logic              sel_bit
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0] idx;

  // only the low index bits count; the rest of the field is dropped
  assign idx     = bitnum[IDX_W-1:0];
  assign mask    = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
  assign sel_bit = |(byte_in & mask);
endmodule

// File: rtl/bitman_modify.sv
module bitman_modify
  import bitman_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bm_op_e            op,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [DATA_W-1:0] mask,
  input  logic              c_in,
  output logic [DATA_W-1:0] byte_nx,
  output logic              we_nx
);
  logic store_val;

  always_comb begin
    store_val = (op == BM_IST) ? ~c_in : c_in;
    byte_nx   = byte_in;
    unique case (op)
      BM_SET:        byte_nx = byte_in | mask;
      BM_CLR:        byte_nx = byte_in & ~mask;
      BM_INV:        byte_nx = byte_in ^ mask;
      BM_ST, BM_IST: byte_nx = (byte_in & ~mask) | (store_val ? mask : '0);
      default:       byte_nx = byte_in;
    endcase
    we_nx = bm_writes(op);
  end
endmodule

// File: rtl/bitman_flag.sv
module bitman_flag
  import bitman_pkg::*;
(
  input  bm_op_e op,
  input  logic   sel_bit,
  input  logic   c_in,
  input  logic   z_in,
  output logic   c_nx,
  output logic   z_nx
);
  logic opnd;

  always_comb begin
    // odd codes among the carry ops use the complemented bit
    opnd = op[0] ? ~sel_bit : sel_bit;
    c_nx = c_in;
    z_nx = z_in;
    unique case (op)
      BM_TST:           z_nx = ~sel_bit;
      BM_LD,  BM_ILD:   c_nx = opnd;
      BM_AND, BM_IAND:  c_nx = opnd & c_in;
      BM_OR,  BM_IOR:   c_nx = opnd | c_in;
      BM_XOR, BM_IXOR:  c_nx = opnd ^ c_in;
      default: begin
        c_nx = c_in;
        z_nx = z_in;
      end
    endcase
  end
endmodule

// File: rtl/bitman_unit.sv
module bitman_unit
  import bitman_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [NUM_W-1:0]  req_bitnum,
  input  logic [DATA_W-1:0] req_byte,
  input  logic              c_in,
  input  logic              z_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_byte,
  output logic              rsp_we,
  output logic              rsp_c,
  output logic              rsp_z
);
  logic [1:0]        rst_sync_q;
  logic              rst_q_n;
  bm_op_e            op;
  logic [DATA_W-1:0] mask;
  logic              sel_bit;
  logic [DATA_W-1:0] byte_nx;
  logic              we_nx;
  logic              c_nx;
  logic              z_nx;
  logic              vld_d;
  logic              we_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign op = bm_op_e'(req_op);

  bitman_decode #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_decode (
    .bitnum  (req_bitnum),
    .byte_in (req_byte),
    .mask    (mask),
    .sel_bit (sel_bit)
  );

  bitman_modify #(.DATA_W(DATA_W)) u_modify (
    .op      (op),
    .byte_in (req_byte),
    .mask    (mask),
    .c_in    (c_in),
    .byte_nx (byte_nx),
    .we_nx   (we_nx)
  );

  bitman_flag u_flag (
    .op      (op),
    .sel_bit (sel_bit),
    .c_in    (c_in),
    .z_in    (z_in),
    .c_nx    (c_nx),
    .z_nx    (z_nx)
  );

  always_comb begin
    vld_d = req_valid;
    we_d  = req_valid & we_nx;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_valid <= 1'b0;
      rsp_we    <= 1'b0;
    end else begin
      rsp_valid <= vld_d;
      rsp_we    <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_byte <= '0;
      rsp_c    <= 1'b0;
      rsp_z    <= 1'b0;
    end else if (req_valid) begin
      rsp_byte <= byte_nx;
      rsp_c    <= c_nx;
      rsp_z    <= z_nx;
    end
  end
endmodule

// File: rtl/bitman_unit_chk.sv
module bitman_unit_chk #(
  parameter int DATA_W = 8,
  parameter int NUM_W  = 8
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              req_valid,
  input logic [3:0]        req_op,
  input logic [NUM_W-1:0]  req_bitnum,
  input logic [DATA_W-1:0] req_byte,
  input logic              c_in,
  input logic              z_in,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_byte,
  input logic              rsp_we,
  input logic              rsp_c,
  input logic              rsp_z
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> rsp_valid);

  // R1
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> (!rsp_valid && !rsp_we && $stable(rsp_byte)));

  // R3
  set_bit_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_op == 4'd0) |=>
      (rsp_we && $countones(rsp_byte ^ $past(req_byte)) <= 1 &&
       rsp_byte[$past(req_bitnum[2:0])]));

  // R4
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_op == 4'd3) |=>
      (!rsp_we && rsp_byte == $past(req_byte) && rsp_c == $past(c_in)));

  // R8
  readonly_no_we_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && (req_op == 4'd3 || req_op > 4'd7 || req_op == 4'd4 || req_op == 4'd5))
      |=> !rsp_we);

  // R9
  z_passthru_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_op != 4'd3) |=> (rsp_z == $past(z_in)));

  // R8
  we_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_we |-> rsp_valid);
endmodule

bind bitman_unit bitman_unit_chk #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_bitnum (req_bitnum),
  .req_byte   (req_byte),
  .c_in       (c_in),
  .z_in       (z_in),
  .rsp_valid  (rsp_valid),
  .rsp_byte   (rsp_byte),
  .rsp_we     (rsp_we),
  .rsp_c      (rsp_c),
  .rsp_z      (rsp_z)
);

// File: tb/test_bitman_unit.sv
`timescale 1ns/1ps
module test_bitman_unit;
  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [3:0] req_op;
  logic [7:0] req_bitnum;
  logic [7:0] req_byte;
  logic       c_in;
  logic       z_in;
  logic       rsp_valid;
  logic [7:0] rsp_byte;
  logic       rsp_we;
  logic       rsp_c;
  logic       rsp_z;

  int n_chk;
  int n_fail;
  bit finished;

  bitman_unit i_bitman_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_bitnum(req_bitnum), .req_byte(req_byte), .c_in(c_in), .z_in(z_in),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_we(rsp_we),
    .rsp_c(rsp_c), .rsp_z(rsp_z)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // expected {byte, we, c, z} from the requirement text
  function automatic logic [10:0] model(input logic [3:0] op, input logic [7:0] b,
                                         input logic [7:0] n, input logic c, input logic z);
    logic [7:0] m;
    logic       bt;
    logic [7:0] rb;
    logic       we;
    logic       rc;
    logic       rz;
    m  = 8'd1 << n[2:0];
    bt = (b & m) != 0;
    rb = b; we = 1'b0; rc = c; rz = z;
    case (op)
      4'd0: begin rb = b | m;  we = 1'b1; end
      4'd1: begin rb = b & ~m; we = 1'b1; end
      4'd2: begin rb = b ^ m;  we = 1'b1; end
      4'd3: rz = !bt;
      4'd4: rc = bt;
      4'd5: rc = !bt;
      4'd6: begin rb = c ? (b | m) : (b & ~m); we = 1'b1; end
      4'd7: begin rb = c ? (b & ~m) : (b | m); we = 1'b1; end
      4'd8: rc = bt & c;
      4'd9: rc = !bt & c;
      4'd10: rc = bt | c;
      4'd11: rc = !bt | c;
      4'd12: rc = bt ^ c;
      4'd13: rc = !bt ^ c;
      default: ;
    endcase
    return {rb, we, rc, rz};
  endfunction

  task automatic issue(input string req, input logic [3:0] op, input logic [7:0] b,
                       input logic [7:0] n, input logic c, input logic z);
    logic [10:0] e;
    e = model(op, b, n, c, z);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_byte = b; req_bitnum = n; c_in = c; z_in = z;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R1 valid"}, int'(rsp_valid), 1);
    check({req, " byte"}, int'(rsp_byte), int'(e[10:3]));
    check({req, " we"}, int'(rsp_we), int'(e[2]));
    check({req, " c"}, int'(rsp_c), int'(e[1]));
    check({req, " z"}, int'(rsp_z), int'(e[0]));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_bitnum = '0;
    req_byte = '0; c_in = 1'b0; z_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", int'(rsp_valid), 0);
    check("R10 reset byte", int'(rsp_byte), 0);
    check("R10 reset flags", int'({rsp_we, rsp_c, rsp_z}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after release", int'({rsp_valid, rsp_we, rsp_byte}), 0);
  endtask

  task automatic t_modify();
    for (int bi = 0; bi < 8; bi++) begin
      issue("R3 set", 4'd0, 8'h00, 8'(bi), 1'b0, 1'b1);
      issue("R3 clr", 4'd1, 8'hFF, 8'(bi), 1'b1, 1'b0);
      issue("R3 inv", 4'd2, 8'hA5, 8'(bi), 1'b0, 1'b0);
    end
  endtask

  task automatic t_test_op();
    issue("R4 test zero bit", 4'd3, 8'hF7, 8'd3, 1'b1, 1'b0);
    issue("R4 test one bit", 4'd3, 8'h08, 8'd3, 1'b0, 1'b1);
  endtask

  task automatic t_load_store();
    for (int ci = 0; ci < 2; ci++) begin
      issue("R5 load", 4'd4, 8'h40, 8'd6, 1'(ci), 1'b1);
      issue("R5 iload", 4'd5, 8'h40, 8'd6, 1'(ci), 1'b0);
      issue("R6 store", 4'd6, 8'h5A, 8'd1, 1'(ci), 1'b0);
      issue("R6 istore", 4'd7, 8'h5A, 8'd2, 1'(ci), 1'b1);
    end
  endtask

  task automatic t_logic_sweep();
    logic [7:0] pats [3];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h6C;
    for (int op = 0; op < 14; op++)
      for (int p = 0; p < 3; p++)
        for (int bi = 0; bi < 8; bi++)
          for (int cz = 0; cz < 4; cz++)
            issue("R7 R9 sweep", 4'(op), pats[p], 8'(bi), cz[1], cz[0]);
  endtask

  task automatic t_high_index();
    issue("R2 index 11", 4'd0, 8'h00, 8'd11, 1'b0, 1'b0);
    issue("R2 index 255", 4'd1, 8'hFF, 8'hFF, 1'b0, 1'b0);
    issue("R2 index 0x80", 4'd4, 8'h01, 8'h80, 1'b0, 1'b0);
  endtask

  task automatic t_reserved();
    issue("R8 code 14", 4'd14, 8'h3C, 8'd2, 1'b1, 1'b0);
    issue("R8 code 15", 4'd15, 8'hC3, 8'd7, 1'b0, 1'b1);
  endtask

  task automatic t_idle();
    issue("R1 prime", 4'd0, 8'h10, 8'd0, 1'b1, 1'b1);
    @(negedge clk);
    check("R1 idle valid", int'(rsp_valid), 0);
    check("R1 idle we", int'(rsp_we), 0);
    check("R1 idle byte held", int'(rsp_byte), 8'h11);
    check("R1 idle flags held", int'({rsp_c, rsp_z}), 3);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    t_reset();
    t_modify();
    t_test_op();
    t_load_store();
    t_high_index();
    t_reserved();
    t_idle();
    t_logic_sweep();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule